// File: doc/BRIEF.md
# Load-Use Stall Controller

This block protects a five-stage in-order integer pipeline from the one dependency that operand bypassing cannot cover: an instruction that reads a register loaded by the memory read directly ahead of it. The consumer is still in decode when the load reaches execute. The block compares the source register fields of the decode-stage instruction with the destination field of the execute-stage load. On a match it holds the program counter and the fetch/decode register for one cycle and replaces the control word entering execute with all zeros. That zero word travels down the pipe as a no-operation. On the next cycle the load has moved on, so the repeated decode sees no hazard, and the loaded value can reach execute through the normal bypass from the write-back stage.

A compact model of the surrounding pipeline registers is part of the block so that the stall can be observed at the ports. The model holds the program counter, the fetched instruction word waiting in decode, the execute-stage control word and the execute-stage target register. A small opcode decoder supplies the control word for each decoded instruction. The instruction memory lies outside the block and returns `fetch_instr` for the current `pc_out`.

Top module: `luh_stall_unit`

## Requirements
- R1: A hazard exists whenever the execute-stage control word has its memory-read bit (bit 0) set and the execute-stage target register equals either the decode instruction's bits [25:21] or its bits [20:16]. The comparison is made even when the instruction ignores the second field and even for register 0. In that cycle `bubble` is 1 and `pc_we` and `ifid_we` are 0, combinationally.
- R2: When the execute-stage memory-read bit is clear, `bubble` is 0 and `pc_we` and `ifid_we` are 1.
- R3: On a clock edge with `bubble` high, `pc_out` and `ifid_instr_out` keep their values, so the same instruction is decoded again and the same address is fetched again.
- R4: On a clock edge with `bubble` high, `idex_ctrl_out` becomes 8'h00.
- R5: On a clock edge without a stall, `pc_out` advances by 4, `ifid_instr_out` loads `fetch_instr`, and `idex_rt_out` loads bits [20:16] of the previous decode instruction.
- R6: A stall lasts exactly one cycle: the cycle after a `bubble` never has `bubble` set.
- R7: Without a stall, `idex_ctrl_out` loads the decoded control of the decode instruction, selected by opcode bits [31:26]. Opcode 0x00 gives 8'hA4, 0x23 (load) gives 8'h1D, 0x2B (store) gives 8'h12, 0x08 (add immediate) gives 8'h14, and every other opcode gives 8'h00. The control word bits are {alu_op[1:0], reg_dst, alu_src, mem_to_reg, reg_write, mem_write, mem_read}.
- R8: A clock edge with synchronous `rst` high clears `pc_out`, `ifid_instr_out`, `idex_ctrl_out` and `idex_rt_out` to zero.
- R9: A load followed by an instruction whose source fields differ from the load's target causes no stall. An instruction that uses the load target two slots after the load also causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_instr | input | 32 | Instruction word read at `pc_out` |
| pc_we | output | 1 | Program counter update enable, low during a stall |
| ifid_we | output | 1 | Fetch/decode register update enable, low during a stall |
| bubble | output | 1 | Zeroes the control word entering execute |
| pc_out | output | 32 | Current program counter |
| ifid_instr_out | output | 32 | Instruction held in the decode stage |
| idex_ctrl_out | output | 8 | Control word held in the execute stage |
| idex_rt_out | output | 5 | Target register field held in the execute stage |

## Verification
On every cycle, the assertions check four things. A bubble freezes the program counter and the decode register. A bubble leaves a zero control word behind it. Two bubbles never occur back to back. A cycle without a bubble advances the program counter by one word. The bench scenarios are needed for the rest. They show that the comparison fires on either source field, on register 0, and on a store's data field. They show that an independent instruction after a load, or a consumer two slots behind it, runs without a stall. They also check the decoded control words and the reset values against a reference model driven by mixed directed and random instruction streams.

// File: rtl/luh_pkg.sv
package luh_pkg;
    localparam int XLEN      = 32;
    localparam int REG_W     = 5;
    localparam int OP_W      = 6;
    localparam int OP_LSB    = 26;
    localparam int SRC1_LSB  = 21;
    localparam int SRC2_LSB  = 16;
    localparam int PC_STEP   = 4;

    localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'h08;

    typedef struct packed {
        logic [1:0] alu_op;
        logic       reg_dst;
        logic       alu_src;
        logic       mem_to_reg;
        logic       reg_write;
        logic       mem_write;
        logic       mem_read;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/luh_ctrl_decode.sv
module luh_ctrl_decode
    import luh_pkg::*;
#(
    parameter int IW = XLEN
) (
    input  logic [IW-1:0] instr,
    output ctrl_t         ctrl
);
    logic [OP_W-1:0] opc;

    always_comb begin
        opc  = instr[OP_LSB +: OP_W];
        ctrl = '0;
        unique case (opc)
            OPC_REG: begin
                ctrl.reg_write = 1'b1;
                ctrl.reg_dst   = 1'b1;
                ctrl.alu_op    = 2'b10;
            end
            OPC_LOAD: begin
                ctrl.mem_read   = 1'b1;
                ctrl.reg_write  = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.alu_src    = 1'b1;
            end
            OPC_STORE: begin
                ctrl.mem_write = 1'b1;
                ctrl.alu_src   = 1'b1;
            end
            OPC_ADDI: begin
                ctrl.reg_write = 1'b1;
                ctrl.alu_src   = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/luh_hazard_detect.sv
module luh_hazard_detect
    import luh_pkg::*;
#(
    parameter int IW = XLEN,
    parameter int RW = REG_W
) (
    input  logic          ex_mem_read,
    input  logic [RW-1:0] ex_target,
    input  logic [IW-1:0] dec_instr,
    output logic          hazard
);
    logic [RW-1:0] src1;
    logic [RW-1:0] src2;
    logic          hit1;
    logic          hit2;

    always_comb begin
        src1   = dec_instr[SRC1_LSB +: RW];
        src2   = dec_instr[SRC2_LSB +: RW];
        hit1   = (src1 == ex_target);
        hit2   = (src2 == ex_target);
        hazard = ex_mem_read && (hit1 || hit2);
    end
endmodule

// File: rtl/luh_stall_ctrl.sv
module luh_stall_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic hazard,
    output logic pc_we,
    output logic ifid_we,
    output logic bubble
);
    always_comb begin
        pc_we   = !hazard;
        ifid_we = !hazard;
        bubble  = hazard;
    end

    assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst && bubble) |=> !bubble);
endmodule

// File: rtl/luh_pipe_regs.sv
module luh_pipe_regs
    import luh_pkg::*;
#(
    parameter int IW   = XLEN,
    parameter int RW   = REG_W,
    parameter int STEP = PC_STEP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pc_we,
    input  logic          ifid_we,
    input  logic          bubble,
    input  logic [IW-1:0] fetch_instr,
    input  ctrl_t         dec_ctrl,
    output logic [IW-1:0] pc,
    output logic [IW-1:0] dec_instr,
    output ctrl_t         ex_ctrl,
    output logic [RW-1:0] ex_target
);
    typedef struct packed {
        logic [IW-1:0] pc;
        logic [IW-1:0] instr;
        ctrl_t         ctrl;
        logic [RW-1:0] target;
    } state_t;

    state_t st_d;
    state_t st_q;

    always_comb begin
        st_d = st_q;
        if (pc_we) begin
            st_d.pc = st_q.pc + IW'(STEP);
        end
        if (ifid_we) begin
            st_d.instr = fetch_instr;
        end
        st_d.ctrl   = bubble ? ctrl_t'('0) : dec_ctrl;
        st_d.target = st_q.instr[SRC2_LSB +: RW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc        = st_q.pc;
    assign dec_instr = st_q.instr;
    assign ex_ctrl   = st_q.ctrl;
    assign ex_target = st_q.target;

    assert_freeze_pc_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && bubble) |=> $stable(st_q.pc));

    assert_freeze_ifid_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && bubble) |=> $stable(st_q.instr));

    assert_zero_ctrl_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst && bubble) |=> (st_q.ctrl == ctrl_t'('0)));

    assert_pc_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!rst && !bubble) |=> (st_q.pc == $past(st_q.pc) + IW'(STEP)));
endmodule

// File: rtl/luh_stall_unit.sv
module luh_stall_unit
    import luh_pkg::*;
#(
    parameter int IW   = XLEN,
    parameter int RW   = REG_W,
    parameter int STEP = PC_STEP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IW-1:0]     fetch_instr,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              bubble,
    output logic [IW-1:0]     pc_out,
    output logic [IW-1:0]     ifid_instr_out,
    output logic [CTRL_W-1:0] idex_ctrl_out,
    output logic [RW-1:0]     idex_rt_out
);
    ctrl_t         dec_ctrl;
    ctrl_t         ex_ctrl;
    logic [IW-1:0] dec_instr;
    logic [RW-1:0] ex_target;
    logic          hazard;

    luh_ctrl_decode #(.IW(IW)) u_decode (
        .instr (dec_instr),
        .ctrl  (dec_ctrl)
    );

    luh_hazard_detect #(.IW(IW), .RW(RW)) u_detect (
        .ex_mem_read (ex_ctrl.mem_read),
        .ex_target   (ex_target),
        .dec_instr   (dec_instr),
        .hazard      (hazard)
    );

    luh_stall_ctrl u_stall (
        .clk     (clk),
        .rst     (rst),
        .hazard  (hazard),
        .pc_we   (pc_we),
        .ifid_we (ifid_we),
        .bubble  (bubble)
    );

    luh_pipe_regs #(.IW(IW), .RW(RW), .STEP(STEP)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .pc_we       (pc_we),
        .ifid_we     (ifid_we),
        .bubble      (bubble),
        .fetch_instr (fetch_instr),
        .dec_ctrl    (dec_ctrl),
        .pc          (pc_out),
        .dec_instr   (dec_instr),
        .ex_ctrl     (ex_ctrl),
        .ex_target   (ex_target)
    );

    assign ifid_instr_out = dec_instr;
    assign idex_ctrl_out  = ex_ctrl;
    assign idex_rt_out    = ex_target;

    assert_no_stall_without_load_R2: assert property (@(posedge clk) disable iff (rst)
        !ex_ctrl.mem_read |-> (!bubble && pc_we && ifid_we));
endmodule

// File: tb/tb_luh_stall_unit.sv
module tb_luh_stall_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_instr = '0;
    logic        pc_we, ifid_we, bubble;
    logic [31:0] pc_out, ifid_instr_out;
    logic [7:0]  idex_ctrl_out;
    logic [4:0]  idex_rt_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] imem [64];
    logic [31:0] m_pc, m_ifid;
    logic [7:0]  m_ctrl;
    logic [4:0]  m_rt;
    logic        m_prev_hz;

    always #5 clk = ~clk;

    luh_stall_unit dut (
        .clk(clk), .rst(rst), .fetch_instr(fetch_instr),
        .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble),
        .pc_out(pc_out), .ifid_instr_out(ifid_instr_out),
        .idex_ctrl_out(idex_ctrl_out), .idex_rt_out(idex_rt_out)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] s1,
                                       input logic [4:0] s2, input logic [4:0] d);
        return {op, s1, s2, d, 11'h0};
    endfunction

    function automatic logic [7:0] exp_ctrl(input logic [31:0] ins);
        case (ins[31:26])
            6'h00:   return 8'hA4;
            6'h23:   return 8'h1D;
            6'h2B:   return 8'h12;
            6'h08:   return 8'h14;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_hz(input logic [7:0] c, input logic [4:0] t,
                                    input logic [31:0] ins);
        return c[0] && (ins[25:21] == t || ins[20:16] == t);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic reset_and_check();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        #1;
        chk(pc_out == 0, "R8 pc", pc_out, 0);
        chk(ifid_instr_out == 0, "R8 ifid", ifid_instr_out, 0);
        chk(idex_ctrl_out == 0, "R8 ctrl", {24'h0, idex_ctrl_out}, 0);
        chk(idex_rt_out == 0, "R8 rt", {27'h0, idex_rt_out}, 0);
        m_pc = 0; m_ifid = 0; m_ctrl = 0; m_rt = 0; m_prev_hz = 0;
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            logic hz;
            if (i != 0) @(negedge clk);
            fetch_instr = imem[m_pc[7:2]];
            #1;
            hz = exp_hz(m_ctrl, m_rt, m_ifid);
            if (m_prev_hz) begin
                chk(pc_out == m_pc, "R3 pc held", pc_out, m_pc);
                chk(ifid_instr_out == m_ifid, "R3 ifid held", ifid_instr_out, m_ifid);
                chk(idex_ctrl_out == 8'h00, "R4 bubble ctrl", {24'h0, idex_ctrl_out}, 0);
                chk(!bubble, "R6 single stall", {31'h0, bubble}, 0);
            end else begin
                chk(pc_out == m_pc, "R5 pc", pc_out, m_pc);
                chk(ifid_instr_out == m_ifid, "R5 ifid", ifid_instr_out, m_ifid);
                chk(idex_ctrl_out == m_ctrl, "R7 ctrl", {24'h0, idex_ctrl_out}, {24'h0, m_ctrl});
            end
            chk(idex_rt_out == m_rt, "R5 rt", {27'h0, idex_rt_out}, {27'h0, m_rt});
            if (hz)
                chk(bubble && !pc_we && !ifid_we, "R1 stall",
                    {29'h0, bubble, pc_we, ifid_we}, 32'h4);
            else if (m_ctrl[0])
                chk(!bubble && pc_we && ifid_we, "R9 load no dependency",
                    {29'h0, bubble, pc_we, ifid_we}, 32'h3);
            else
                chk(!bubble && pc_we && ifid_we, "R2 no load",
                    {29'h0, bubble, pc_we, ifid_we}, 32'h3);
            m_rt   = m_ifid[20:16];
            m_ctrl = hz ? 8'h00 : exp_ctrl(m_ifid);
            if (!hz) begin
                m_pc   = m_pc + 4;
                m_ifid = fetch_instr;
            end
            m_prev_hz = hz;
        end
        @(negedge clk);
    endtask

    initial begin
        logic [5:0] ops [5];
        void'($urandom(32'h5EED));
        ops = '{6'h00, 6'h23, 6'h2B, 6'h08, 6'h04};
        imem[0]  = mk(6'h23, 5'd1, 5'd2, 5'd0);
        imem[1]  = mk(6'h00, 5'd2, 5'd5, 5'd6);
        imem[2]  = mk(6'h23, 5'd1, 5'd3, 5'd0);
        imem[3]  = mk(6'h00, 5'd6, 5'd3, 5'd7);
        imem[4]  = mk(6'h23, 5'd0, 5'd4, 5'd0);
        imem[5]  = mk(6'h00, 5'd5, 5'd6, 5'd8);
        imem[6]  = mk(6'h00, 5'd4, 5'd4, 5'd9);
        imem[7]  = mk(6'h23, 5'd0, 5'd7, 5'd0);
        imem[8]  = mk(6'h2B, 5'd9, 5'd7, 5'd0);
        imem[9]  = mk(6'h08, 5'd7, 5'd7, 5'd0);
        imem[10] = mk(6'h23, 5'd1, 5'd0, 5'd0);
        imem[11] = mk(6'h00, 5'd0, 5'd5, 5'd6);
        imem[12] = mk(6'h23, 5'd1, 5'd8, 5'd0);
        imem[13] = mk(6'h23, 5'd8, 5'd9, 5'd0);
        imem[14] = mk(6'h00, 5'd9, 5'd1, 5'd2);
        imem[15] = mk(6'h3F, 5'd2, 5'd3, 5'd4);
        for (int k = 16; k < 64; k++)
            imem[k] = mk(ops[$urandom_range(0, 4)], 5'($urandom_range(0, 3)),
                         5'($urandom_range(0, 3)), 5'($urandom_range(0, 31)));
        reset_and_check();
        run_cycles(24);
        run_cycles(300);
        reset_and_check();
        run_cycles(40);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule